// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block is a memory protection unit with sixteen entries. Each entry holds an 8-bit configuration byte and a 32-bit boundary register. Software-side logic loads both through an indexed register port. Every memory access presents a byte address, an access kind and a privilege flag, and the block answers allow or deny in the same cycle.

An entry matches in one of two ways. In range mode, its boundary is an exclusive upper limit, and the entry below it supplies the inclusive lower limit. In power-of-two mode, the boundary encodes an aligned block whose size comes from its count of trailing one bits. When several entries cover an address, the lowest-numbered one decides. A lock bit freezes an entry against further writes and also applies its permissions to machine-mode accesses. A locked range entry also protects its predecessor's boundary, because that boundary is its own lower limit.

Top module: `pmp_checker`

## Requirements
- R1: After reset every configuration byte and boundary register reads as zero, a lower-privilege access is denied and a machine-mode access is allowed.
- R2: The configuration byte places read permission at bit 0, write at bit 1, execute at bit 2, the match mode at bits 4:3 and the lock at bit 7. Bits 6:5 ignore writes and read as zero. A configuration read returns zero in bits 31:8.
- R3: Match mode 0 matches nothing, 1 selects range mode, 3 selects power-of-two mode, and 2 matches nothing.
- R4: In range mode, entry 0 matches when the access byte address bits 31:2 are below its boundary.
- R5: In range mode, entry i>0 matches when boundary i-1 is at most the access address bits 31:2 and those bits are below boundary i.
- R6: In power-of-two mode, a boundary with k trailing ones covers 2^(k+3) bytes at the base given by the remaining bits, shifted left by 2. The smallest region is 8 bytes.
- R7: When several entries match, only the lowest-numbered matching entry decides the result.
- R8: An access that matches no entry is allowed in machine mode and denied at lower privilege.
- R9: A lower-privilege access, or a machine-mode access that matches a locked entry, gets the matching entry's permission for its kind (access kind 0 read, 1 write, 2 execute). A machine-mode access that matches an unlocked entry is allowed.
- R10: Writes to the configuration byte or the boundary of a locked entry are ignored.
- R11: A write to boundary i is ignored while entry i+1 is locked and in range mode.
- R12: The allow result depends combinationally on the current access inputs. A register write becomes visible only after the next rising clock edge.
- R13: Access kind 3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel_addr | input | 1 | 0 selects the configuration byte, 1 selects the boundary register |
| reg_idx | input | 4 | Entry index for the register port |
| reg_wdata | input | 32 | Write data (bits 7:0 for a configuration byte) |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_addr | input | 32 | Byte address of the access |
| acc_type | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 invalid |
| acc_mmode | input | 1 | 1 for a machine-mode access |
| acc_allow | output | 1 | 1 when the access is permitted |

## Verification
Several properties hold on every cycle. The assertions check that a locked entry never changes, that a boundary guarded by a locked range successor stays put, that the reserved bits stay zero, that the access-kind-3 denial holds, and that the fallback decision applies whenever every entry is off. Region arithmetic can only be shown by the bench's scenarios, which probe chosen addresses. These cover range edges, power-of-two sizing, overlap priority, the effect of the lock on machine mode, and the one-edge delay of a write.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF  = 2'd0,
        MATCH_TOR  = 2'd1,
        MATCH_RSV  = 2'd2,
        MATCH_POW2 = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_BAD   = 2'd3
    } acc_kind_e;

    // bit 7 lock, 6:5 reserved, 4:3 mode, 2 x, 1 w, 0 r
    typedef struct packed {
        logic        lock;
        logic [1:0]  rsv;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } ent_cfg_t;

    localparam logic [7:0] CFG_WMASK = 8'h9F;

endpackage

// File: rtl/pmp_regfile.sv
module pmp_regfile
    import pmp_chk_pkg::*;
#(
    parameter int unsigned N_ENT = 16,
    parameter int unsigned AW    = 32,
    parameter int unsigned IDXW  = $clog2(N_ENT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic                          sel_addr,
    input  logic [IDXW-1:0]               idx,
    input  logic [AW-1:0]                 wdata,
    output logic [AW-1:0]                 rdata,
    output ent_cfg_t [N_ENT-1:0]          cfg_o,
    output logic [N_ENT-1:0][AW-1:0]      bnd_o
);

    ent_cfg_t [N_ENT-1:0]     cfg_q;
    logic [N_ENT-1:0][AW-1:0] bnd_q;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic hit;
        logic guard;

        assign hit = we && (idx == IDXW'(i));

        if (i < N_ENT - 1) begin : g_guard
            assign guard = cfg_q[i+1].lock && (cfg_q[i+1].mode == MATCH_TOR);
        end else begin : g_last
            assign guard = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
                bnd_q[i] <= '0;
            end else begin
                if (hit && !sel_addr && !cfg_q[i].lock) begin
                    cfg_q[i] <= ent_cfg_t'(wdata[7:0] & CFG_WMASK);
                end
                if (hit && sel_addr && !cfg_q[i].lock && !guard) begin
                    bnd_q[i] <= wdata;
                end
            end
        end
    end

    always_comb begin
        if (sel_addr) begin
            rdata = bnd_q[idx];
        end else begin
            rdata = {{(AW-8){1'b0}}, cfg_q[idx]};
        end
    end

    assign cfg_o = cfg_q;
    assign bnd_o = bnd_q;

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_chk_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  match_mode_e   mode,
    input  logic [AW-1:0] bnd,
    input  logic [AW-1:0] prev_bnd,
    input  logic [AW-1:0] acc_word,
    output logic          hit
);

    logic [AW-1:0] pow2_mask;
    logic          in_range;
    logic          in_block;

    // trailing ones plus the first zero become the don't-care bits
    assign pow2_mask = bnd ^ (bnd + 1'b1);
    assign in_block  = ((acc_word ^ bnd) & ~pow2_mask) == '0;
    assign in_range  = (acc_word >= prev_bnd) && (acc_word < bnd);

    always_comb begin
        unique case (mode)
            MATCH_OFF:  hit = 1'b0;
            MATCH_TOR:  hit = in_range;
            MATCH_RSV:  hit = 1'b0;
            MATCH_POW2: hit = in_block;
        endcase
    end

endmodule

// File: rtl/pmp_decide.sv
module pmp_decide
    import pmp_chk_pkg::*;
#(
    parameter int unsigned N_ENT = 16,
    parameter int unsigned IDXW  = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0]     hits,
    input  ent_cfg_t [N_ENT-1:0] cfg,
    input  logic [1:0]           acc_type,
    input  logic                 acc_mmode,
    output logic                 allow
);

    logic            found;
    logic [IDXW-1:0] pick;
    ent_cfg_t        win;
    logic            perm;
    logic            unused_cfg_bits;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                pick  = IDXW'(i);
            end
        end
    end

    assign win             = cfg[pick];
    assign unused_cfg_bits = ^{win.rsv, win.mode};

    always_comb begin
        unique case (acc_kind_e'(acc_type))
            ACC_READ:  perm = win.r;
            ACC_WRITE: perm = win.w;
            ACC_EXEC:  perm = win.x;
            ACC_BAD:   perm = 1'b0;
        endcase
    end

    always_comb begin
        if (acc_kind_e'(acc_type) == ACC_BAD) begin
            allow = 1'b0;
        end else if (!found) begin
            allow = acc_mmode;
        end else if (acc_mmode && !win.lock) begin
            allow = 1'b1;
        end else begin
            allow = perm;
        end
    end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_chk_pkg::*;
#(
    parameter int unsigned N_ENT = 16,
    parameter int unsigned AW    = 32,
    parameter int unsigned IDXW  = $clog2(N_ENT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic            reg_sel_addr,
    input  logic [IDXW-1:0] reg_idx,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    input  logic [AW-1:0]   acc_addr,
    input  logic [1:0]      acc_type,
    input  logic            acc_mmode,
    output logic            acc_allow
);

    ent_cfg_t [N_ENT-1:0]     cfg_q;
    logic [N_ENT-1:0][AW-1:0] bnd_q;
    logic [N_ENT-1:0]         hits;
    logic [AW-1:0]            acc_word;
    logic                     unused_lsb;

    assign acc_word   = {2'b00, acc_addr[AW-1:2]};
    assign unused_lsb = ^acc_addr[1:0];

    pmp_regfile #(.N_ENT(N_ENT), .AW(AW), .IDXW(IDXW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .sel_addr (reg_sel_addr),
        .idx      (reg_idx),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cfg_o    (cfg_q),
        .bnd_o    (bnd_q)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_match
        logic [AW-1:0] lower;
        if (i == 0) begin : g_first
            assign lower = '0;
        end else begin : g_rest
            assign lower = bnd_q[i-1];
        end

        pmp_region_match #(.AW(AW)) u_match (
            .mode     (cfg_q[i].mode),
            .bnd      (bnd_q[i]),
            .prev_bnd (lower),
            .acc_word (acc_word),
            .hit      (hits[i])
        );
    end

    pmp_decide #(.N_ENT(N_ENT), .IDXW(IDXW)) u_decide (
        .hits      (hits),
        .cfg       (cfg_q),
        .acc_type  (acc_type),
        .acc_mmode (acc_mmode),
        .allow     (acc_allow)
    );

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
    parameter int unsigned N_ENT = 16,
    parameter int unsigned AW    = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_sel_addr,
    input logic [AW-1:0]            reg_rdata,
    input logic [1:0]               acc_type,
    input logic                     acc_mmode,
    input logic                     acc_allow,
    input logic [N_ENT-1:0][7:0]    cfg_q,
    input logic [N_ENT-1:0][AW-1:0] bnd_q
);

    logic any_on;
    always_comb begin
        any_on = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (cfg_q[i][4:3] != 2'd0) any_on = 1'b1;
        end
    end

    AST_CFG_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel_addr |-> (reg_rdata[AW-1:8] == '0) && (reg_rdata[6:5] == 2'b00)); // R2

    AST_BAD_KIND_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 2'd3) |-> !acc_allow); // R13

    AST_ALL_OFF_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_on && acc_type != 2'd3) |-> (acc_allow == acc_mmode)); // R8

    for (genvar j = 0; j < N_ENT; j++) begin : g_ent
        AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[j][6:5] == 2'b00); // R2

        AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[j][7] |=> $stable(cfg_q[j]) && $stable(bnd_q[j])); // R10

        if (j < N_ENT - 1) begin : g_guard
            AST_TOR_LOWER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[j+1][7] && cfg_q[j+1][4:3] == 2'd1) |=> $stable(bnd_q[j])); // R11
        end
    end

endmodule

bind pmp_checker pmp_checker_sva #(.N_ENT(N_ENT), .AW(AW)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_sel_addr (reg_sel_addr),
    .reg_rdata    (reg_rdata),
    .acc_type     (acc_type),
    .acc_mmode    (acc_mmode),
    .acc_allow    (acc_allow),
    .cfg_q        (cfg_q),
    .bnd_q        (bnd_q)
);

// File: tb/pmp_checker_tb.sv
`timescale 1ns/1ps
module pmp_checker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel_addr = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_type = '0;
    logic        acc_mmode = 1'b0;
    logic        acc_allow;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pmp_checker u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel_addr(reg_sel_addr),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_addr(acc_addr), .acc_type(acc_type), .acc_mmode(acc_mmode),
        .acc_allow(acc_allow)
    );

    // {byte address, kind, machine, expected allow}
    localparam logic [35:0] VEC [0:21] = '{
        {32'h0000_0FFC, 2'd0, 1'b0, 1'b1},  // R4 entry0 read
        {32'h0000_0FFC, 2'd1, 1'b0, 1'b0},  // R4 entry0 no write
        {32'h0000_1000, 2'd1, 1'b0, 1'b1},  // R5 entry1 lower edge
        {32'h0000_1FFC, 2'd0, 1'b0, 1'b1},  // R5 entry1 top word
        {32'h0000_2000, 2'd0, 1'b0, 1'b0},  // R8 no match user
        {32'h0000_4000, 2'd2, 1'b0, 1'b1},  // R6 block base
        {32'h0000_4FFC, 2'd2, 1'b0, 1'b1},  // R6 block end
        {32'h0000_5000, 2'd2, 1'b0, 1'b0},  // R6 past block
        {32'h0000_4000, 2'd0, 1'b0, 1'b0},  // R6 no read perm
        {32'h0000_1804, 2'd1, 1'b0, 1'b1},  // R7 entry1 beats entry3
        {32'h0000_0000, 2'd1, 1'b1, 1'b1},  // R9 machine unlocked
        {32'h0000_8000, 2'd1, 1'b1, 1'b0},  // R9 machine locked no W
        {32'h0000_8004, 2'd0, 1'b1, 1'b1},  // R9 machine locked R
        {32'h0000_8008, 2'd1, 1'b1, 1'b1},  // R8/R6 outside 8-byte block
        {32'h0000_C000, 2'd0, 1'b0, 1'b0},  // R3 mode 2 matches nothing
        {32'h0000_8000, 2'd0, 1'b0, 1'b1},  // R9 user locked R
        {32'h0000_1000, 2'd3, 1'b1, 1'b0},  // R13 bad kind
        {32'h0001_4008, 2'd1, 1'b1, 1'b1},  // R5 locked range W
        {32'h0001_4008, 2'd2, 1'b1, 1'b0},  // R9 locked range no X
        {32'h0001_4010, 2'd2, 1'b1, 1'b1},  // R5 upper bound excluded
        {32'h0001_4000, 2'd0, 1'b0, 1'b1},  // R5 lower bound included
        {32'h0001_3FFC, 2'd0, 1'b0, 1'b0}   // R5 below lower bound
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic s, input int i, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel_addr = s; reg_idx = 4'(i); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic s, input int i, output logic [31:0] v);
        reg_sel_addr = s; reg_idx = 4'(i);
        #1;
        v = reg_rdata;
    endtask

    task automatic acc(input logic [31:0] a, input logic [1:0] t, input logic m, output logic v);
        acc_addr = a; acc_type = t; acc_mmode = m;
        #1;
        v = acc_allow;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #100000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic        a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, 0, v);  chk(v, 32'h0, "R1 cfg0 reset");
        rd(1'b1, 15, v); chk(v, 32'h0, "R1 bnd15 reset");
        acc(32'h0000_1000, 2'd0, 1'b0, a); chk(32'(a), 32'h0, "R1 user denied");
        acc(32'h0000_1000, 2'd1, 1'b1, a); chk(32'(a), 32'h1, "R1 machine allowed");

        // R12 write takes effect at the next edge, not before
        @(negedge clk);
        reg_we = 1'b1; reg_sel_addr = 1'b0; reg_idx = 4'd9; reg_wdata = 32'h01;
        #1; chk(reg_rdata, 32'h0, "R12 before edge");
        @(negedge clk);
        reg_we = 1'b0;
        #1; chk(reg_rdata, 32'h01, "R12 after edge");
        wr(1'b0, 9, 32'h0);

        // program regions
        wr(1'b1, 0, 32'h0000_0400); wr(1'b0, 0, 32'h09);        // range [0,0x1000) R
        wr(1'b1, 1, 32'h0000_0800); wr(1'b0, 1, 32'h0B);        // range [0x1000,0x2000) RW
        wr(1'b1, 2, 32'h0000_11FF); wr(1'b0, 2, 32'h1C);        // 4 KiB at 0x4000 X
        wr(1'b1, 3, 32'h0000_0600); wr(1'b0, 3, 32'h18);        // 8 B at 0x1800 none
        wr(1'b1, 4, 32'h0000_2000); wr(1'b0, 4, 32'h99);        // 8 B at 0x8000 R locked
        wr(1'b1, 5, 32'h0000_3000); wr(1'b0, 5, 32'h17);        // mode 2
        wr(1'b0, 6, 32'h6F);                                    // reserved bits set
        wr(1'b1, 7, 32'h0000_5000);
        wr(1'b1, 8, 32'h0000_5004); wr(1'b0, 8, 32'h8B);        // locked range RW

        rd(1'b0, 6, v); chk(v, 32'h0F, "R2 reserved bits dropped");
        rd(1'b0, 4, v); chk(v, 32'h99, "R2 lock byte readback");

        for (int k = 0; k < 22; k++) begin
            acc(VEC[k][35:4], VEC[k][3:2], VEC[k][1], a);
            chk(32'(a), 32'(VEC[k][0]), $sformatf("vector %0d (R3-R9,R13 set)", k));
        end

        // R10 locked entry ignores writes
        wr(1'b0, 8, 32'h00); rd(1'b0, 8, v); chk(v, 32'h8B, "R10 locked cfg held");
        wr(1'b1, 8, 32'h1234); rd(1'b1, 8, v); chk(v, 32'h5004, "R10 locked bnd held");
        // R11 predecessor of a locked range entry
        wr(1'b1, 7, 32'h1234); rd(1'b1, 7, v); chk(v, 32'h5000, "R11 lower bound held");
        // successor locked but power-of-two: write lands
        wr(1'b1, 3, 32'h0000_0601); rd(1'b1, 3, v); chk(v, 32'h601, "R11 non-range successor");
        // unlocked entry still writable
        wr(1'b1, 10, 32'hCAFE_0000); rd(1'b1, 10, v); chk(v, 32'hCAFE_0000, "R10 unlocked write");

        finish_run();
    end

endmodule